// File: doc/BRIEF.md
# Frame Fetch Sequencer with In-Buffer Header

This block sequences the memory reads for one display frame. Enabling it checks that every frame buffer in use lies inside the addressable window. Each frame tick then starts a fetch. Unless the palette is bypassed, the fetch first issues one 512-byte palette read from the top of the current buffer. The memory side returns the depth field (bits 14:12 of the first palette word). From that field the block derives the bits per pixel and the byte offset where pixel data begins.

It then checks that the pixel area fits the buffer. If it fits, it issues one read request per display line, each one stride long. Each request is a start address and a byte length, and it holds until the memory side accepts it. The block can alternate between two buffers. A subpanel setting either moves the first fetched line or caps the last one. An undersized buffer raises a sync error and turns the block off.

An asynchronous active-low reset is released through a two-stage synchronizer. Pixel unpacking and colour conversion happen downstream.

Top module: `fbf_fetch_seq`

## Requirements
- R1: After reset the block is disabled, no request is valid, `buf_idle` is 1, and `frame_done`, `pal_done`, `sync_err` and `dma_cond` are all 0.
- R2: An enable write (`cfg_wr` with `cfg_en`=1 while disabled) checks the top and bottom addresses of buffer 0, and of buffer 1 only when `cfg_dual` is 1, against the window [MEM_LO, MEM_HI). If any address is outside, `dma_cond[2]` is set and the block stays disabled.
- R3: A successful enable while `buf_idle` is 1 sets `buf_sel` to 0 and clears `buf_idle`, `frame_done` and `pal_done`. An enable after an automatic turn-off (`buf_idle` 0) leaves those flags as they were.
- R4: With `cfg_pal_mode` equal to 0 or 3, a `frame_start` pulse while enabled and idle issues a read of 512 bytes at the top of the current buffer. The `hdr_depth` value returned with `hdr_valid` is captured, and `pal_done` becomes 1.
- R5: The depth code maps to bits per pixel as 1→2, 2→4, 3→8 and 4..7→16. Pixel data starts 0x200 bytes past the buffer top for codes 3..7 and 0x20 bytes past it for codes 1..2. The line stride is width×bpp/8 bytes.
- R6: Depth code 0 ends the frame after the palette read. No line request is issued and `buf_sel` is unchanged.
- R7: In palette mode 2 no palette read is made, pixel data starts at offset 0, and the depth code is the last one captured. In palette mode 1 a frame tick issues no request at all.
- R8: If offset + width×height×bpp/8 exceeds (bottom − top) + 2, `sync_err` becomes 1, the block turns itself off, and no line request is issued. Equality is accepted.
- R9: When line fetching starts, `dma_cond[b]` is set for the buffer `b` being fetched. In dual mode `buf_sel` then toggles, so consecutive frames read buffer 0 and buffer 1 in turn.
- R10: With `sub_on`=1 and `sub_is_start`=1, fetching begins at line `sub_line` and runs to the last line. With `sub_on`=1 and `sub_is_start`=0, only lines 0 .. `sub_line`−1 are fetched. If the first line is not below the end line, no line is fetched.
- R11: A disable write clears `sync_err`, sets `buf_idle`, abandons any fetch in progress, and sets `frame_done` unless the written `cfg_pal_mode` is 1. A configuration write takes priority over a `frame_start` or a handshake in the same cycle.
- R12: A request holds its address and length until `rd_ready`. Line n of a frame is requested at data base + n×stride.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe for the enable bit |
| cfg_en | input | 1 | Enable value written with `cfg_wr` |
| cfg_pal_mode | input | 2 | Palette mode: 0/3 load, 1 no fetch, 2 bypass |
| cfg_dual | input | 1 | Alternate between two buffers |
| cfg_width | input | DIM_W | Pixels per line |
| cfg_height | input | DIM_W | Lines per frame |
| sub_on | input | 1 | Subpanel trimming active |
| sub_is_start | input | 1 | 1: sub_line is first line; 0: line limit |
| sub_line | input | SUB_W | Subpanel line value |
| buf0_top | input | AW | Buffer 0 first byte address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 first byte address |
| buf1_bot | input | AW | Buffer 1 end address |
| frame_start | input | 1 | Frame tick |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read request start address |
| rd_len | output | AW | Read request length in bytes |
| rd_ready | input | 1 | Read request accepted |
| hdr_valid | input | 1 | Depth field of palette word 0 is present |
| hdr_depth | input | 3 | Bits 14:12 of palette word 0 |
| enabled | output | 1 | Block is enabled |
| buf_sel | output | 1 | Current buffer index |
| buf_idle | output | 1 | Buffer index holds the idle marker |
| frame_done | output | 1 | Frame-done flag |
| pal_done | output | 1 | Palette-done flag |
| sync_err | output | 1 | Buffer too small for the frame |
| dma_cond | output | 3 | Sticky: [0]/[1] buffer fetched, [2] bad bounds |

## Verification
Two pairs of events can land in the same cycle. The first pair is a disable write and the handshake of a line request. The bench raises `rd_ready` and writes `cfg_en`=0 on the same edge. It then expects the request to vanish, no further line to appear, and `frame_done` and `buf_idle` to be set. The second pair is an enable write and a frame tick. Driving both together must produce no request, and a frame tick issued later must start the palette read normally.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  localparam int PAL_BYTES  = 512;
  localparam int OFF_SHORT  = 32;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_PAL_REQ,
    ST_PAL_WAIT,
    ST_CHECK,
    ST_LINE
  } fbf_state_e;

  typedef struct packed {
    logic       ok;
    logic [4:0] bpp;
    logic [9:0] off;
  } depth_info_t;

endpackage

// File: rtl/fbf_hdr_decode.sv
module fbf_hdr_decode
  import fbf_pkg::*;
(
  input  logic [2:0]  code,
  input  logic [1:0]  pal_mode,
  output depth_info_t info
);

  always_comb begin
    info.ok = 1'b1;
    unique case (code)
      3'd0:    begin info.ok = 1'b0; info.bpp = 5'd0; end
      3'd1:    info.bpp = 5'd2;
      3'd2:    info.bpp = 5'd4;
      3'd3:    info.bpp = 5'd8;
      default: info.bpp = 5'd16;
    endcase
    if (pal_mode == 2'd2)  info.off = '0;
    else if (code >= 3'd3) info.off = 10'(PAL_BYTES);
    else                   info.off = 10'(OFF_SHORT);
  end

endmodule

// File: rtl/fbf_span_calc.sv
module fbf_span_calc #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DIM_W = 11,
  parameter int unsigned SUB_W = 10
) (
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [4:0]       bpp,
  input  logic [9:0]       off,
  input  logic [AW-1:0]    top,
  input  logic [AW-1:0]    bot,
  input  logic             sub_on,
  input  logic             sub_is_start,
  input  logic [SUB_W-1:0] sub_line,
  output logic [AW-1:0]    stride,
  output logic [AW-1:0]    data_base,
  output logic             too_small,
  output logic [DIM_W-1:0] first_line,
  output logic [DIM_W-1:0] end_line
);

  localparam int PW = 2*DIM_W + 5;
  localparam int SW = DIM_W + 5;

  logic [PW-1:0] pix_bits;
  logic [SW-1:0] row_bits;
  logic [AW:0]   need;
  logic [AW:0]   room;

  always_comb begin
    pix_bits   = PW'(width) * PW'(height) * PW'(bpp);
    row_bits   = SW'(width) * SW'(bpp);
    stride     = AW'(row_bits >> 3);
    need       = (AW+1)'(off) + (AW+1)'(pix_bits >> 3);
    room       = {1'b0, bot - top} + (AW+1)'(2);
    too_small  = need > room;
    first_line = (sub_on && sub_is_start)  ? DIM_W'(sub_line) : '0;
    end_line   = (sub_on && !sub_is_start) ? DIM_W'(sub_line) : height;
    data_base  = top + AW'(off) + stride * AW'(first_line);
  end

endmodule

// File: rtl/fbf_fetch_seq.sv
module fbf_fetch_seq
  import fbf_pkg::*;
#(
  parameter int unsigned   AW     = 32,
  parameter int unsigned   DIM_W  = 11,
  parameter int unsigned   SUB_W  = 10,
  parameter logic [AW-1:0] MEM_LO = '0,
  parameter logic [AW-1:0] MEM_HI = 'h1_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_pal_mode,
  input  logic             cfg_dual,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic             sub_on,
  input  logic             sub_is_start,
  input  logic [SUB_W-1:0] sub_line,
  input  logic [AW-1:0]    buf0_top,
  input  logic [AW-1:0]    buf0_bot,
  input  logic [AW-1:0]    buf1_top,
  input  logic [AW-1:0]    buf1_bot,
  input  logic             frame_start,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_addr,
  output logic [AW-1:0]    rd_len,
  input  logic             rd_ready,
  input  logic             hdr_valid,
  input  logic [2:0]       hdr_depth,
  output logic             enabled,
  output logic             buf_sel,
  output logic             buf_idle,
  output logic             frame_done,
  output logic             pal_done,
  output logic             sync_err,
  output logic [2:0]       dma_cond
);

  // reset synchronizer: asserts at once, releases on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  fbf_state_e       state_q, state_d;
  logic             en_q, en_d;
  logic             sel_q, sel_d;
  logic             idle_q, idle_d;
  logic             fdone_q, fdone_d;
  logic             pdone_q, pdone_d;
  logic             serr_q, serr_d;
  logic [2:0]       cond_q, cond_d;
  logic [2:0]       hdr_q, hdr_d;
  logic [AW-1:0]    laddr_q, laddr_d;
  logic [AW-1:0]    lstride_q, lstride_d;
  logic [DIM_W-1:0] lidx_q, lidx_d;
  logic [DIM_W-1:0] lend_q, lend_d;

  depth_info_t      dinfo;
  logic [AW-1:0]    cur_top, cur_bot;
  logic [AW-1:0]    sp_stride, sp_base;
  logic             sp_small;
  logic [DIM_W-1:0] sp_first, sp_end;
  logic [DIM_W:0]   lidx_inc;
  logic             bounds_ok, cfg_change;

  function automatic logic in_win(input logic [AW-1:0] a);
    return (a - MEM_LO) < (MEM_HI - MEM_LO);
  endfunction

  assign cur_top = sel_q ? buf1_top : buf0_top;
  assign cur_bot = sel_q ? buf1_bot : buf0_bot;

  fbf_hdr_decode u_dec (
    .code     (hdr_q),
    .pal_mode (cfg_pal_mode),
    .info     (dinfo)
  );

  fbf_span_calc #(.AW(AW), .DIM_W(DIM_W), .SUB_W(SUB_W)) u_span (
    .width        (cfg_width),
    .height       (cfg_height),
    .bpp          (dinfo.bpp),
    .off          (dinfo.off),
    .top          (cur_top),
    .bot          (cur_bot),
    .sub_on       (sub_on),
    .sub_is_start (sub_is_start),
    .sub_line     (sub_line),
    .stride       (sp_stride),
    .data_base    (sp_base),
    .too_small    (sp_small),
    .first_line   (sp_first),
    .end_line     (sp_end)
  );

  assign bounds_ok  = in_win(buf0_top) && in_win(buf0_bot) &&
                      (!cfg_dual || (in_win(buf1_top) && in_win(buf1_bot)));
  assign cfg_change = cfg_wr && (cfg_en != en_q);
  assign lidx_inc   = {1'b0, lidx_q} + 1'b1;

  // next-state process
  always_comb begin
    state_d   = state_q;
    en_d      = en_q;
    sel_d     = sel_q;
    idle_d    = idle_q;
    fdone_d   = fdone_q;
    pdone_d   = pdone_q;
    serr_d    = serr_q;
    cond_d    = cond_q;
    hdr_d     = hdr_q;
    laddr_d   = laddr_q;
    lstride_d = lstride_q;
    lidx_d    = lidx_q;
    lend_d    = lend_q;
    if (cfg_change && cfg_en) begin
      if (!bounds_ok) begin
        cond_d[2] = 1'b1;
      end else begin
        en_d    = 1'b1;
        state_d = ST_IDLE;
        if (idle_q) begin
          idle_d  = 1'b0;
          sel_d   = 1'b0;
          fdone_d = 1'b0;
          pdone_d = 1'b0;
        end
      end
    end else if (cfg_change) begin
      en_d    = 1'b0;
      idle_d  = 1'b1;
      serr_d  = 1'b0;
      state_d = ST_OFF;
      if (cfg_pal_mode != 2'd1) fdone_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (frame_start && cfg_pal_mode != 2'd1)
            state_d = (cfg_pal_mode == 2'd2) ? ST_CHECK : ST_PAL_REQ;
        end
        ST_PAL_REQ: begin
          if (rd_ready) state_d = ST_PAL_WAIT;
        end
        ST_PAL_WAIT: begin
          if (hdr_valid) begin
            hdr_d   = hdr_depth;
            pdone_d = 1'b1;
            state_d = ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!dinfo.ok) begin
            state_d = ST_IDLE;
          end else if (sp_small) begin
            serr_d  = 1'b1;
            en_d    = 1'b0;
            state_d = ST_OFF;
          end else begin
            cond_d[sel_q] = 1'b1;
            if (cfg_dual) sel_d = ~sel_q;
            laddr_d   = sp_base;
            lstride_d = sp_stride;
            lidx_d    = sp_first;
            lend_d    = sp_end;
            state_d   = (sp_first < sp_end) ? ST_LINE : ST_IDLE;
          end
        end
        ST_LINE: begin
          if (rd_ready) begin
            laddr_d = laddr_q + lstride_q;
            lidx_d  = lidx_inc[DIM_W-1:0];
            if (lidx_inc >= {1'b0, lend_q}) state_d = ST_IDLE;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_OFF;
      en_q      <= 1'b0;
      sel_q     <= 1'b0;
      idle_q    <= 1'b1;
      fdone_q   <= 1'b0;
      pdone_q   <= 1'b0;
      serr_q    <= 1'b0;
      cond_q    <= '0;
      hdr_q     <= '0;
      laddr_q   <= '0;
      lstride_q <= '0;
      lidx_q    <= '0;
      lend_q    <= '0;
    end else begin
      state_q   <= state_d;
      en_q      <= en_d;
      sel_q     <= sel_d;
      idle_q    <= idle_d;
      fdone_q   <= fdone_d;
      pdone_q   <= pdone_d;
      serr_q    <= serr_d;
      cond_q    <= cond_d;
      hdr_q     <= hdr_d;
      laddr_q   <= laddr_d;
      lstride_q <= lstride_d;
      lidx_q    <= lidx_d;
      lend_q    <= lend_d;
    end
  end

  assign rd_valid   = (state_q == ST_PAL_REQ) || (state_q == ST_LINE);
  assign rd_addr    = (state_q == ST_PAL_REQ) ? cur_top : laddr_q;
  assign rd_len     = (state_q == ST_PAL_REQ) ? AW'(PAL_BYTES) : lstride_q;
  assign enabled    = en_q;
  assign buf_sel    = sel_q;
  assign buf_idle   = idle_q;
  assign frame_done = fdone_q;
  assign pal_done   = pdone_q;
  assign sync_err   = serr_q;
  assign dma_cond   = cond_q;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && !rd_ready && !cfg_wr) |=> (rd_valid && $stable(rd_addr) && $stable(rd_len)));

  // R8
  sync_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sync_err) |-> !enabled);

  // R11
  idle_marker_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buf_idle |-> !enabled);

  // R11
  no_req_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enabled |-> !rd_valid);

  // R4
  pal_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pal_done) |-> $past(hdr_valid));

endmodule

// File: tb/fbf_fetch_seq_test.sv
module fbf_fetch_seq_test;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_en, cfg_dual;
  logic [1:0]  cfg_pal_mode;
  logic [10:0] cfg_width, cfg_height;
  logic        sub_on, sub_is_start;
  logic [9:0]  sub_line;
  logic [31:0] buf0_top, buf0_bot, buf1_top, buf1_bot;
  logic        frame_start;
  logic        rd_valid, rd_ready;
  logic [31:0] rd_addr, rd_len;
  logic        hdr_valid;
  logic [2:0]  hdr_depth;
  logic        enabled, buf_sel, buf_idle, frame_done, pal_done, sync_err;
  logic [2:0]  dma_cond;

  int errs   = 0;
  int checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  fbf_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_pal_mode(cfg_pal_mode), .cfg_dual(cfg_dual),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .sub_on(sub_on), .sub_is_start(sub_is_start), .sub_line(sub_line),
    .buf0_top(buf0_top), .buf0_bot(buf0_bot),
    .buf1_top(buf1_top), .buf1_bot(buf1_bot),
    .frame_start(frame_start), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_ready(rd_ready), .hdr_valid(hdr_valid),
    .hdr_depth(hdr_depth), .enabled(enabled), .buf_sel(buf_sel),
    .buf_idle(buf_idle), .frame_done(frame_done), .pal_done(pal_done),
    .sync_err(sync_err), .dma_cond(dma_cond)
  );

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_en(input logic v);
    @(negedge clk); cfg_wr = 1'b1; cfg_en = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic take_req(input logic [31:0] ea, input logic [31:0] el, input string req);
    int n = 0;
    @(negedge clk); rd_ready = 1'b0;
    while (!rd_valid && n < 30) begin @(negedge clk); n++; end
    chk_eq(req, "request present", rd_valid, 1);
    if (rd_valid) begin
      chk_eq(req, "rd_addr", rd_addr, ea);
      chk_eq(req, "rd_len", rd_len, el);
      rd_ready = 1'b1;
    end
  endtask

  task automatic send_hdr(input logic [2:0] code);
    @(negedge clk); rd_ready = 1'b0; hdr_valid = 1'b1; hdr_depth = code;
    @(negedge clk); hdr_valid = 1'b0;
  endtask

  task automatic idle_check(input int n, input string req);
    int cnt = 0;
    @(negedge clk); rd_ready = 1'b0;
    repeat (n) begin
      if (rd_valid) cnt++;
      @(negedge clk);
    end
    chk_eq(req, "no extra request", cnt, 0);
  endtask

  task automatic run_frame(input logic [2:0] code, input bit with_pal,
                           input logic [31:0] pal_addr, input logic [31:0] line0,
                           input logic [31:0] stride, input int nlines, input string req);
    pulse_start();
    if (with_pal) begin
      take_req(pal_addr, 32'h200, req);
      send_hdr(code);
    end
    for (int i = 0; i < nlines; i++) take_req(line0 + i*stride, stride, req);
    idle_check(6, req);
  endtask

  task automatic t_reset();
    chk_eq("R1", "enabled", enabled, 0);
    chk_eq("R1", "rd_valid", rd_valid, 0);
    chk_eq("R1", "buf_idle", buf_idle, 1);
    chk_eq("R1", "flags", {frame_done, pal_done, sync_err}, 0);
    chk_eq("R1", "dma_cond", dma_cond, 0);
  endtask

  task automatic t_basic();
    write_en(1'b1);
    chk_eq("R3", "enabled", enabled, 1);
    chk_eq("R3", "buf_idle", buf_idle, 0);
    chk_eq("R3", "done flags", {frame_done, pal_done}, 0);
    run_frame(3'd3, 1, 32'h1000, 32'h1200, 16, 4, "R4");
    chk_eq("R4", "pal_done", pal_done, 1);
    chk_eq("R9", "dma_cond", dma_cond, 3'b001);
    chk_eq("R9", "buf_sel single", buf_sel, 0);
  endtask

  task automatic t_depths();
    run_frame(3'd1, 1, 32'h1000, 32'h1020, 4, 4, "R5");
    run_frame(3'd2, 1, 32'h1000, 32'h1020, 8, 4, "R5");
    run_frame(3'd4, 1, 32'h1000, 32'h1200, 32, 4, "R5");
    run_frame(3'd7, 1, 32'h1000, 32'h1200, 32, 4, "R5");
  endtask

  task automatic t_code0();
    run_frame(3'd0, 1, 32'h1000, 32'h0, 16, 0, "R6");
    chk_eq("R6", "buf_sel", buf_sel, 0);
    chk_eq("R6", "enabled", enabled, 1);
  endtask

  task automatic t_subpanel();
    sub_on = 1'b1; sub_is_start = 1'b1; sub_line = 10'd2;
    run_frame(3'd3, 1, 32'h1000, 32'h1220, 16, 2, "R10");
    sub_is_start = 1'b0; sub_line = 10'd3;
    run_frame(3'd3, 1, 32'h1000, 32'h1200, 16, 3, "R10");
    sub_is_start = 1'b1; sub_line = 10'd5;
    run_frame(3'd3, 1, 32'h1000, 32'h1200, 16, 0, "R10");
    sub_on = 1'b0;
  endtask

  task automatic t_modes();
    cfg_pal_mode = 2'd2;
    run_frame(3'd0, 0, 32'h0, 32'h1000, 16, 4, "R7");
    cfg_pal_mode = 2'd1;
    run_frame(3'd0, 0, 32'h0, 32'h0, 16, 0, "R7");
    write_en(1'b0);
    chk_eq("R11", "frame_done mode1", frame_done, 0);
    chk_eq("R11", "buf_idle", buf_idle, 1);
    chk_eq("R11", "enabled", enabled, 0);
    cfg_pal_mode = 2'd0;
    write_en(1'b1);
    write_en(1'b0);
    chk_eq("R11", "frame_done mode0", frame_done, 1);
    write_en(1'b1);
    chk_eq("R3", "flags cleared", {frame_done, pal_done}, 0);
    write_en(1'b0);
  endtask

  task automatic t_dual();
    cfg_dual = 1'b1;
    write_en(1'b1);
    chk_eq("R3", "buf_sel restart", buf_sel, 0);
    run_frame(3'd3, 1, 32'h1000, 32'h1200, 16, 4, "R9");
    chk_eq("R9", "toggled to 1", buf_sel, 1);
    run_frame(3'd3, 1, 32'h4000, 32'h4200, 16, 4, "R9");
    chk_eq("R9", "toggled to 0", buf_sel, 0);
    chk_eq("R9", "dma_cond[1]", dma_cond[1], 1);
    write_en(1'b0);
    cfg_dual = 1'b0;
  endtask

  task automatic t_sync();
    write_en(1'b1);
    buf0_bot = 32'h123E;
    run_frame(3'd3, 1, 32'h1000, 32'h1200, 16, 4, "R8");
    chk_eq("R8", "no error at equality", sync_err, 0);
    buf0_bot = 32'h123D;
    run_frame(3'd3, 1, 32'h1000, 32'h0, 16, 0, "R8");
    chk_eq("R8", "sync_err", sync_err, 1);
    chk_eq("R8", "auto off", enabled, 0);
    write_en(1'b1);
    chk_eq("R3", "re-enable", enabled, 1);
    chk_eq("R3", "pal_done kept", pal_done, 1);
    chk_eq("R3", "sync_err kept", sync_err, 1);
    write_en(1'b0);
    chk_eq("R11", "sync_err cleared", sync_err, 0);
    chk_eq("R11", "frame_done", frame_done, 1);
    buf0_bot = 32'h1400;
  endtask

  task automatic t_bounds();
    buf1_top = 32'h2_0000;
    write_en(1'b1);
    chk_eq("R2", "buf1 ignored single", enabled, 1);
    chk_eq("R2", "no bound error", dma_cond[2], 0);
    write_en(1'b0);
    cfg_dual = 1'b1;
    write_en(1'b1);
    chk_eq("R2", "refused", enabled, 0);
    chk_eq("R2", "dma_cond[2]", dma_cond[2], 1);
    cfg_dual = 1'b0;
    buf1_top = 32'h4000;
  endtask

  task automatic t_coincide();
    @(negedge clk); cfg_wr = 1'b1; cfg_en = 1'b1; frame_start = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; frame_start = 1'b0;
    chk_eq("R11", "enabled", enabled, 1);
    idle_check(4, "R11");
    pulse_start();
    take_req(32'h1000, 32'h200, "R11");
    send_hdr(3'd3);
    take_req(32'h1200, 32'd16, "R11");
    cfg_wr = 1'b1; cfg_en = 1'b0;
    @(negedge clk); cfg_wr = 1'b0; rd_ready = 1'b0;
    chk_eq("R11", "request dropped", rd_valid, 0);
    chk_eq("R11", "disabled", enabled, 0);
    chk_eq("R11", "frame_done", frame_done, 1);
    chk_eq("R11", "buf_idle", buf_idle, 1);
    idle_check(4, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0; cfg_dual = 1'b0;
    cfg_pal_mode = 2'd0; cfg_width = 11'd16; cfg_height = 11'd4;
    sub_on = 1'b0; sub_is_start = 1'b0; sub_line = '0;
    buf0_top = 32'h1000; buf0_bot = 32'h1400;
    buf1_top = 32'h4000; buf1_bot = 32'h4400;
    frame_start = 1'b0; rd_ready = 1'b0; hdr_valid = 1'b0; hdr_depth = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_depths();
    t_code0();
    t_subpanel();
    t_modes();
    t_dual();
    t_sync();
    t_bounds();
    t_coincide();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule